// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds a small set of ownership flags that two independent ports, left and right, use to reserve shared resources. The flags are separate from any data storage. A port selects a flag through the low bits of its address while its semaphore select strobe is high, and issues a write or a read in the same clock cycle. Writing a zero in data bit 0 asks for the flag, and writing a one gives it back.

A read reports to the port whether it holds the flag. Every data bit is driven low when the reading port is the owner and high otherwise, so a free flag reads as all ones from both sides. A port that asks for a flag held by the other side is remembered as waiting. When the owner gives the flag back, the waiting port becomes the owner in that same cycle, without having to ask again. When both ports ask for a free flag in the same cycle, the left port gets it and the right port is left waiting.

Read results sit in a register per port. A write from the opposite port therefore cannot disturb a value that has already been returned.

Top module: `sem_latch_bank`

## Requirements
- R1: After reset every flag is free, no request is waiting, and both read data outputs are all ones.
- R2: The flag is chosen by address bits [2:0] (with NUM_SEM = 8). The higher address bits have no effect. Each flag is independent of the others.
- R3: A write uses only data bit 0. A value of 0 requests the flag, a value of 1 releases or withdraws it, and the other data bits are ignored. A request to a free flag makes the writer the owner at once.
- R4: A read returns 0x00 (all bits low) to the port that owns the flag, and 0xFF (all bits high) to the other port or when the flag is free.
- R5: Only the owner can release a flag. A write of 1 by the non-owner never changes who owns the flag.
- R6: If the non-owner has a waiting request, ownership passes to it in the same cycle the owner writes 1, including a request written in that same cycle.
- R7: A waiting port that writes 1 withdraws its request. A later release by the owner then leaves the flag free.
- R8: Read data is registered. It shows the result of a read one clock after the read strobe, it reflects the flag state before any write in that same cycle, and it holds its value in cycles without a read, whatever the other port writes.
- R9: When both ports request the same free flag in the same cycle, the left port becomes the owner and the right port's request is kept as waiting.
- R10: Read and write strobes have no effect while the port's semaphore select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port semaphore select |
| l_rd | input | 1 | Left port read strobe |
| l_wr | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address; the low bits pick the flag |
| l_wdata | input | DATA_W | Left port write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left port registered read result |
| r_sel | input | 1 | Right port semaphore select |
| r_rd | input | 1 | Right port read strobe |
| r_wr | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address; the low bits pick the flag |
| r_wdata | input | DATA_W | Right port write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right port registered read result |

## Verification
The bench builds the block with its default parameters: NUM_SEM = 8, DATA_W = 8 and ADDR_W = 13. With these values the upper ten address bits and the upper seven data bits can be set to non-zero patterns, which shows that they are ignored. The eight flags leave room to hold several flags in different states at the same time, so the bench can confirm that one flag changing does not disturb another. The 8-bit read width makes the all-zero and all-one read patterns clearly different from any mixed value.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic   want_l;
        logic   want_r;
        owner_e owner;
    } flag_t;

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               rd,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SEM-1:0] set_vec,
    output logic [NUM_SEM-1:0] clr_vec,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_idx
);

    logic             wr_en;
    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    assign idx         = addr[IDX_W-1:0];
    assign wr_en       = sel && wr;
    assign rd_en       = sel && rd;
    assign rd_idx      = idx;
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_hit
        logic hit;
        assign hit        = wr_en && (idx == IDX_W'(i));
        assign set_vec[i] = hit && !wdata[0];
        assign clr_vec[i] = hit &&  wdata[0];
    end

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_l,
    input  logic clr_l,
    input  logic set_r,
    input  logic clr_r,
    output logic own_l,
    output logic own_r,
    output logic pend_l,
    output logic pend_r
);

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (set_l)      st_d.want_l = 1'b1;
        else if (clr_l) st_d.want_l = 1'b0;

        if (set_r)      st_d.want_r = 1'b1;
        else if (clr_r) st_d.want_r = 1'b0;

        if (st_q.owner == OWN_LEFT && st_d.want_l)
            st_d.owner = OWN_LEFT;
        else if (st_q.owner == OWN_RIGHT && st_d.want_r)
            st_d.owner = OWN_RIGHT;
        else if (st_d.want_l)
            st_d.owner = OWN_LEFT;
        else if (st_d.want_r)
            st_d.owner = OWN_RIGHT;
        else
            st_d.owner = OWN_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{want_l: 1'b0, want_r: 1'b0, owner: OWN_NONE};
        else        st_q <= st_d;
    end

    assign own_l  = (st_q.owner == OWN_LEFT);
    assign own_r  = (st_q.owner == OWN_RIGHT);
    assign pend_l = st_q.want_l && !own_l;
    assign pend_r = st_q.want_r && !own_r;

endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] own_vec,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en)
            rdata_d = {DATA_W{~own_vec[rd_idx]}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '1;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/sem_latch_bank.sv
module sem_latch_bank #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_rd,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_rd,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);

    logic [NUM_SEM-1:0] set_l_vec, clr_l_vec, set_r_vec, clr_r_vec;
    logic [NUM_SEM-1:0] own_l_vec, own_r_vec, pend_l_vec, pend_r_vec;
    logic               l_rd_en, r_rd_en;
    logic [IDX_W-1:0]   l_rd_idx, r_rd_idx;

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel     (l_sel),
        .rd      (l_rd),
        .wr      (l_wr),
        .addr    (l_addr),
        .wdata   (l_wdata),
        .set_vec (set_l_vec),
        .clr_vec (clr_l_vec),
        .rd_en   (l_rd_en),
        .rd_idx  (l_rd_idx)
    );

    sem_port_decode #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel     (r_sel),
        .rd      (r_rd),
        .wr      (r_wr),
        .addr    (r_addr),
        .wdata   (r_wdata),
        .set_vec (set_r_vec),
        .clr_vec (clr_r_vec),
        .rd_en   (r_rd_en),
        .rd_idx  (r_rd_idx)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_flag
        sem_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_l  (set_l_vec[i]),
            .clr_l  (clr_l_vec[i]),
            .set_r  (set_r_vec[i]),
            .clr_r  (clr_r_vec[i]),
            .own_l  (own_l_vec[i]),
            .own_r  (own_r_vec[i]),
            .pend_l (pend_l_vec[i]),
            .pend_r (pend_r_vec[i])
        );
    end

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_l (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (l_rd_en),
        .rd_idx  (l_rd_idx),
        .own_vec (own_l_vec),
        .rdata   (l_rdata)
    );

    sem_read_reg #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_rd_r (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (r_rd_en),
        .rd_idx  (r_rd_idx),
        .own_vec (own_r_vec),
        .rdata   (r_rdata)
    );

endmodule

// File: rtl/sem_latch_bank_chk.sv
module sem_latch_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel,
    input logic               l_rd,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel,
    input logic               r_rd,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] own_l_vec,
    input logic [NUM_SEM-1:0] own_r_vec,
    input logic [NUM_SEM-1:0] pend_l_vec,
    input logic [NUM_SEM-1:0] pend_r_vec,
    input logic [NUM_SEM-1:0] set_l_vec,
    input logic [NUM_SEM-1:0] clr_l_vec,
    input logic [NUM_SEM-1:0] set_r_vec,
    input logic [NUM_SEM-1:0] clr_r_vec
);

    // R5: an owner keeps its flag unless it wrote a release
    a_r5_left_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(own_l_vec & ~clr_l_vec)) & ~own_l_vec) == '0);
    a_r5_right_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(own_r_vec & ~clr_r_vec)) & ~own_r_vec) == '0);

    // R6: a waiting port takes over when the owner releases
    a_r6_hand_to_right: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(own_l_vec & clr_l_vec & pend_r_vec & ~clr_r_vec)) & ~own_r_vec) == '0);
    a_r6_hand_to_left: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(own_r_vec & clr_r_vec & pend_l_vec & ~clr_l_vec)) & ~own_l_vec) == '0);

    // R7: a withdraw by the non-owner leaves no waiting request
    a_r7_withdraw_right: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(clr_r_vec & ~own_r_vec)) & pend_r_vec) == '0);

    // R9: the left port wins a tie on a free flag
    a_r9_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(~own_l_vec & ~own_r_vec & set_l_vec & set_r_vec)) & ~own_l_vec) == '0);

    // R4: a read result is all low or all high
    a_r4_left_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_rd) |=> (l_rdata == '0 || l_rdata == '1));
    a_r4_right_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel && r_rd) |=> (r_rdata == '0 || r_rdata == '1));

    // R8: read data holds without a read
    a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_sel && l_rd) |=> $stable(l_rdata));
    a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_sel && r_rd) |=> $stable(r_rdata));

endmodule

bind sem_latch_bank sem_latch_bank_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sem_latch_bank.sv
module tb_sem_latch_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        l_sel = 0, l_rd = 0, l_wr = 0;
    logic [12:0] l_addr = '0;
    logic [7:0]  l_wdata = '0;
    logic [7:0]  l_rdata;
    logic        r_sel = 0, r_rd = 0, r_wr = 0;
    logic [12:0] r_addr = '0;
    logic [7:0]  r_wdata = '0;
    logic [7:0]  r_rdata;

    int total = 0;
    int bad   = 0;
    int ncount = 0;

    int         q_due[$];
    bit         q_port[$];
    logic [7:0] q_exp[$];
    string      q_tag[$];

    // reference model: 0 free, 1 left, 2 right
    int   m_own [8];
    bit   m_wl  [8];
    bit   m_wr  [8];
    logic [7:0] last_l = 8'hFF;
    logic [7:0] last_r = 8'hFF;

    always #10 clk = ~clk;

    sem_latch_bank dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        ncount++;
        while (q_due.size() > 0 && q_due[0] <= ncount) begin
            if (q_port[0] == 1'b0) chk({q_tag[0], " left"},  l_rdata, q_exp[0]);
            else                   chk({q_tag[0], " right"}, r_rdata, q_exp[0]);
            void'(q_due.pop_front());
            void'(q_port.pop_front());
            void'(q_exp.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic cyc(input logic ls, input logic lr, input logic lw,
                       input logic [12:0] la, input logic [7:0] lwd,
                       input logic rs, input logic rr, input logic rw,
                       input logic [12:0] ra, input logic [7:0] rwd,
                       input string tag);
        @(posedge clk);
        #2;
        l_sel = ls; l_rd = lr; l_wr = lw; l_addr = la; l_wdata = lwd;
        r_sel = rs; r_rd = rr; r_wr = rw; r_addr = ra; r_wdata = rwd;
        if (ls && lr) last_l = (m_own[la[2:0]] == 1) ? 8'h00 : 8'hFF;
        if (rs && rr) last_r = (m_own[ra[2:0]] == 2) ? 8'h00 : 8'hFF;
        q_due.push_back(ncount + 2); q_port.push_back(1'b0);
        q_exp.push_back(last_l);     q_tag.push_back(tag);
        q_due.push_back(ncount + 2); q_port.push_back(1'b1);
        q_exp.push_back(last_r);     q_tag.push_back(tag);
        for (int i = 0; i < 8; i++) begin
            if (ls && lw && la[2:0] == 3'(i)) m_wl[i] = !lwd[0];
            if (rs && rw && ra[2:0] == 3'(i)) m_wr[i] = !rwd[0];
            if (m_own[i] == 1 && m_wl[i])      m_own[i] = 1;
            else if (m_own[i] == 2 && m_wr[i]) m_own[i] = 2;
            else if (m_wl[i])                  m_own[i] = 1;
            else if (m_wr[i])                  m_own[i] = 2;
            else                               m_own[i] = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++)
            cyc(0,0,0,13'h0,8'h0, 0,0,0,13'h0,8'h0, "R8 idle");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_own[i] = 0; m_wl[i] = 0; m_wr[i] = 0; end
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset left",  l_rdata, 8'hFF);
        chk("R1 reset right", r_rdata, 8'hFF);

        cyc(1,1,0,13'h0,8'h0,     1,1,0,13'h7,8'h0,   "R1");
        cyc(1,0,1,13'h2,8'hFE,    0,0,0,13'h0,8'h0,   "R3");
        cyc(1,1,0,13'h2,8'h0,     1,1,0,13'h2,8'h0,   "R4");
        cyc(1,1,0,13'h1FFA,8'h0,  1,0,1,13'h0402,8'h00, "R2");
        cyc(0,0,0,13'h0,8'h0,     1,0,1,13'h2,8'h01,  "R7");
        cyc(1,1,0,13'h2,8'h0,     1,1,0,13'h2,8'h0,   "R5");
        cyc(1,0,1,13'h2,8'h01,    0,0,0,13'h0,8'h0,   "R7");
        cyc(1,1,0,13'h2,8'h0,     1,1,0,13'h2,8'h0,   "R7");
        cyc(0,0,0,13'h0,8'h0,     1,0,1,13'h2,8'h00,  "R3");
        cyc(1,0,1,13'h2,8'h00,    0,0,0,13'h0,8'h0,   "R6");
        cyc(1,1,0,13'h2,8'h0,     1,1,0,13'h2,8'h0,   "R4");
        cyc(0,0,0,13'h0,8'h0,     1,0,1,13'h2,8'hFF,  "R6");
        cyc(1,1,0,13'h2,8'h0,     1,1,0,13'h2,8'h0,   "R6");
        cyc(1,0,1,13'h2,8'h01,    0,0,0,13'h0,8'h0,   "R3");
        cyc(1,0,1,13'h5,8'hAA,    0,0,0,13'h0,8'h0,   "R3");
        cyc(1,1,0,13'h5,8'h0,     1,1,0,13'h2,8'h0,   "R3");
        cyc(1,0,1,13'h5,8'h55,    0,0,0,13'h0,8'h0,   "R3");
        cyc(1,1,0,13'h5,8'h0,     1,1,0,13'h5,8'h0,   "R3");
        cyc(1,0,1,13'h4,8'h00,    1,0,1,13'h4,8'h00,  "R9");
        cyc(1,1,0,13'h4,8'h0,     1,1,0,13'h4,8'h0,   "R9");
        cyc(1,0,1,13'h4,8'h01,    0,0,0,13'h0,8'h0,   "R9");
        cyc(1,1,0,13'h4,8'h0,     1,1,0,13'h4,8'h0,   "R9");
        cyc(0,0,1,13'h6,8'h00,    0,1,0,13'h2,8'h0,   "R10");
        cyc(1,1,0,13'h6,8'h0,     1,1,0,13'h6,8'h0,   "R10");
        cyc(1,1,1,13'h7,8'h00,    0,0,0,13'h0,8'h0,   "R8");
        cyc(1,1,0,13'h7,8'h0,     0,0,0,13'h0,8'h0,   "R8");
        cyc(1,1,0,13'h4,8'h0,     0,0,0,13'h0,8'h0,   "R8");
        cyc(1,0,1,13'h4,8'h00,    1,0,1,13'h4,8'h01,  "R8");
        cyc(1,1,0,13'h4,8'h0,     1,1,0,13'h4,8'h0,   "R8");
        cyc(1,0,1,13'h7,8'h01,    1,0,1,13'h7,8'h00,  "R6");
        cyc(1,1,0,13'h7,8'h0,     1,1,0,13'h7,8'h0,   "R6");
        idle(4);
        @(negedge clk);
        @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule